// File: doc/BRIEF.md
# Program Counter Steering Unit

This block owns the 32-bit program counter of a simple in-order core and picks the address of the next fetch every cycle. By default the counter steps by one instruction, four bytes. A decoded branch kind can replace that step with a PC-relative branch or with a region-local jump. A branch moves by a signed 16-bit count of instructions, measured from the instruction after the current one. A jump keeps the top four address bits and replaces everything below them with a 26-bit instruction index.

Branch decisions come from two register operands. There are two forms that compare the operands with each other for equality. There are four forms that look only at the first operand, as a signed value, against zero. A stall input freezes the counter for a cycle. A synchronous active-low reset loads a parameterized start address. The `taken_o` output is combinational and shows whether the current decision redirects the fetch stream. The registered `pc_o` takes the chosen address at the next rising edge.

Top module: `pc_steer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc_o` is loaded with `RESET_VEC` (default 0x0040_0000). `taken_o` is 0 while `rst_n` is low.
- R2: Kind code 0 (sequential) makes the next `pc_o` equal to `pc_o + 4`, wrapping modulo 2^32, with `taken_o` = 0.
- R3: Kind code 1 redirects when `opa_i == opb_i`. Kind code 2 redirects when `opa_i != opb_i`.
- R4: Kind codes 3, 4, 5 and 6 redirect when `opa_i`, read as signed, is `< 0`, `> 0`, `<= 0` and `>= 0` respectively. `opb_i` has no effect on these kinds.
- R5: A redirecting branch loads `pc_o + 4 + 4*sext(off16_i)`, so a negative offset moves backward (the range runs from -32768 to +32767 instructions). A branch that does not redirect loads `pc_o + 4` with `taken_o` = 0.
- R6: Kind code 7 (jump) always redirects. It loads `{pc_o[31:28], tgt26_i, 2'b00}` and sets `taken_o` = 1.
- R7: With `hold_i` = 1 (and reset released), `pc_o` keeps its value at the edge and `taken_o` is 0, whatever the kind.
- R8: `pc_o[1:0]` is 00 after every update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_i | input | 1 | Stall: freeze the counter and mask the redirect flag |
| kind_i | input | 3 | Decoded branch kind, codes 0 to 7 as in R2 to R6 |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand (equality kinds only) |
| off16_i | input | 16 | Signed branch offset in instructions |
| tgt26_i | input | 26 | Jump instruction index |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Current decision redirects the fetch stream |

## Verification
The assertions take for granted that `rst_n` is held low for at least one rising edge before any other check matters. They also take `RESET_VEC` to be word aligned, and `kind_i` to be a known value whenever reset is released. The bench drives every input at the falling edge, so all values are stable around each rising edge. The reset pulse spans two edges. Only the eight defined kind codes are applied. A second instance, with a start address near the top of memory, is driven in lockstep so that jumps keep a non-zero upper nibble and the sequential step wraps through zero.

// File: rtl/pcs_pkg.sv
// Shared types for the program counter steering unit.
// Assumes every instruction is one aligned 32-bit word.
package pcs_pkg;

    // Decoded branch kind; codes are decoded by the steering logic.
    typedef enum logic [2:0] {
        BK_SEQ = 3'd0,
        BK_EQ  = 3'd1,
        BK_NE  = 3'd2,
        BK_LTZ = 3'd3,
        BK_GTZ = 3'd4,
        BK_LEZ = 3'd5,
        BK_GEZ = 3'd6,
        BK_JMP = 3'd7
    } br_kind_e;

endpackage

// File: rtl/pcs_cond.sv
// Branch condition evaluator.
// Decides, for a conditional kind, whether the branch redirects.
// Assumes opa/opb are the already-read register values; jump and
// sequential kinds never produce a redirect here.
module pcs_cond
    import pcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  br_kind_e          kind,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              take
);

    logic a_neg;
    logic a_zero;
    logic a_eq_b;

    // Operand flags shared by all comparisons.
    always_comb begin
        a_neg  = $signed(opa) < $signed({DATA_W{1'b0}});
        a_zero = (opa == '0);
        a_eq_b = (opa == opb);
    end

    // Select the condition that matches the decoded kind.
    always_comb begin
        unique case (kind)
            BK_EQ:   take = a_eq_b;
            BK_NE:   take = !a_eq_b;
            BK_LTZ:  take = a_neg;
            BK_GTZ:  take = !a_neg && !a_zero;
            BK_LEZ:  take = a_neg || a_zero;
            BK_GEZ:  take = !a_neg;
            default: take = 1'b0;
        endcase
    end

    p_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_EQ) |-> (take == ~|(opa ^ opb)));

    p_ne_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_NE) |-> (take == |(opa ^ opb)));

    p_ltz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_LTZ) |-> (take == opa[DATA_W-1]));

    p_gtz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_GTZ && take) |-> (!opa[DATA_W-1] && |opa));

endmodule

// File: rtl/pcs_target.sv
// Next-address generator.
// Forms the sequential, branch and jump candidates and picks one.
// Assumes pc is aligned to the instruction size; JUMP_HI_FROM_INC
// selects whether the kept upper bits come from pc or from pc + step.
module pcs_target #(
    parameter int PC_W             = 32,
    parameter int OFF_W            = 16,
    parameter int JMP_W            = 26,
    parameter int ALIGN            = 2,
    parameter bit JUMP_HI_FROM_INC = 1'b0
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [JMP_W-1:0] tgt,
    input  logic             sel_branch,
    input  logic             sel_jump,
    output logic [PC_W-1:0]  next_pc
);

    localparam int HI_W  = PC_W - JMP_W - ALIGN;
    localparam int EXT_W = PC_W - OFF_W - ALIGN;
    localparam logic [PC_W-1:0] STEP = PC_W'(1 << ALIGN);

    logic [PC_W-1:0] inc_pc;
    logic [PC_W-1:0] br_pc;
    logic [PC_W-1:0] jmp_pc;
    logic [PC_W-1:0] off_bytes;
    logic [HI_W-1:0] hi_bits;

    // Sequential step and offset scaled to bytes.
    always_comb begin
        inc_pc    = pc + STEP;
        off_bytes = {{EXT_W{off[OFF_W-1]}}, off, {ALIGN{1'b0}}};
        br_pc     = inc_pc + off_bytes;
    end

    // Source of the upper bits kept by a jump.
    generate
        if (JUMP_HI_FROM_INC) begin : g_hi_inc
            assign hi_bits = inc_pc[PC_W-1 -: HI_W];
        end else begin : g_hi_cur
            assign hi_bits = pc[PC_W-1 -: HI_W];
        end
    endgenerate

    // Region-local jump address.
    always_comb jmp_pc = {hi_bits, tgt, {ALIGN{1'b0}}};

    // Final candidate selection.
    always_comb begin
        if (sel_jump)        next_pc = jmp_pc;
        else if (sel_branch) next_pc = br_pc;
        else                 next_pc = inc_pc;
    end

endmodule

// File: rtl/pc_steer.sv
// Program counter steering unit (top).
// Holds the program counter and advances it by step, branch or jump.
// Assumes kind_i is decoded from the instruction at pc_o in the same
// cycle; no delay slot; RESET_VEC must be aligned.
module pc_steer
    import pcs_pkg::*;
#(
    parameter int          PC_W             = 32,
    parameter int          OFF_W            = 16,
    parameter int          JMP_W            = 26,
    parameter int          ALIGN            = 2,
    parameter bit          JUMP_HI_FROM_INC = 1'b0,
    parameter logic [31:0] RESET_VEC        = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [2:0]       kind_i,
    input  logic [PC_W-1:0]  opa_i,
    input  logic [PC_W-1:0]  opb_i,
    input  logic [OFF_W-1:0] off16_i,
    input  logic [JMP_W-1:0] tgt26_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             taken_o
);

    localparam int HI_W = PC_W - JMP_W - ALIGN;
    localparam logic [PC_W-1:0] STEP  = PC_W'(1 << ALIGN);
    localparam logic [PC_W-1:0] RVEC  = PC_W'(RESET_VEC);

    br_kind_e        kind;
    logic            cond_take;
    logic            is_jump;
    logic [PC_W-1:0] next_pc;

    // Decode the kind code.
    always_comb begin
        kind    = br_kind_e'(kind_i);
        is_jump = (kind == BK_JMP);
    end

    pcs_cond #(
        .DATA_W (PC_W)
    ) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .opa   (opa_i),
        .opb   (opb_i),
        .take  (cond_take)
    );

    pcs_target #(
        .PC_W             (PC_W),
        .OFF_W            (OFF_W),
        .JMP_W            (JMP_W),
        .ALIGN            (ALIGN),
        .JUMP_HI_FROM_INC (JUMP_HI_FROM_INC)
    ) u_target (
        .pc         (pc_o),
        .off        (off16_i),
        .tgt        (tgt26_i),
        .sel_branch (cond_take),
        .sel_jump   (is_jump),
        .next_pc    (next_pc)
    );

    // Redirect flag, masked by reset and stall.
    always_comb taken_o = rst_n && !hold_i && (is_jump || cond_take);

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_o <= RVEC;
        else if (!hold_i) pc_o <= next_pc;
    end

    p_reset_vec_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == RVEC));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !taken_o);

    p_untaken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken_o && !hold_i) |=> (pc_o == $past(pc_o) + STEP));

    p_seq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_SEQ) |-> !taken_o);

    p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && !hold_i && !JUMP_HI_FROM_INC) |=>
        ((pc_o[PC_W-1 -: HI_W] == $past(pc_o[PC_W-1 -: HI_W])) &&
         (pc_o[PC_W-HI_W-1:ALIGN] == $past(tgt26_i))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(pc_o));

    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> !taken_o);

    p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[ALIGN-1:0] == '0);

endmodule

// File: tb/pc_steer_bench.sv
`timescale 1ns/1ps
// Directed bench: two instances in lockstep, one per start address.
module pc_steer_bench;

    localparam logic [31:0] VEC_LO = 32'h0040_0000;
    localparam logic [31:0] VEC_HI = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_i = 1'b0;
    logic [2:0]  kind_i = 3'd0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] off16_i = '0;
    logic [25:0] tgt26_i = '0;
    logic [31:0] pc_lo, pc_hi;
    logic        tk_lo, tk_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_lo, exp_hi;

    always #2.5 clk = ~clk;

    pc_steer u_pc_steer (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .kind_i(kind_i),
        .opa_i(opa_i), .opb_i(opb_i), .off16_i(off16_i), .tgt26_i(tgt26_i),
        .pc_o(pc_lo), .taken_o(tk_lo)
    );

    pc_steer #(.RESET_VEC(VEC_HI)) u_pc_steer_hi (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .kind_i(kind_i),
        .opa_i(opa_i), .opb_i(opb_i), .off16_i(off16_i), .tgt26_i(tgt26_i),
        .pc_o(pc_hi), .taken_o(tk_hi)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Redirect decision from the requirement text (R2..R7).
    function automatic bit want_take(input logic [2:0] k, input logic [31:0] a,
                                     input logic [31:0] b, input bit h);
        int sa;
        sa = $signed(a);
        if (h) return 1'b0;
        case (k)
            3'd1: return a == b;
            3'd2: return a != b;
            3'd3: return sa < 0;
            3'd4: return sa > 0;
            3'd5: return sa <= 0;
            3'd6: return sa >= 0;
            3'd7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] want_pc(input logic [31:0] pc, input logic [2:0] k,
                                            input bit t, input bit h,
                                            input logic [15:0] off, input logic [25:0] tg);
        logic [31:0] sx;
        sx = {{16{off[15]}}, off};
        if (h) return pc;
        if (k == 3'd7) return {pc[31:28], tg, 2'b00};
        if (t) return pc + 32'd4 + (sx << 2);
        return pc + 32'd4;
    endfunction

    // One cycle: drive at falling edge, check flag, check pc at next falling edge.
    task automatic step(input string req, input logic [2:0] k, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] off,
                        input logic [25:0] tg, input bit h);
        bit t;
        kind_i = k; opa_i = a; opb_i = b; off16_i = off; tgt26_i = tg; hold_i = h;
        t = want_take(k, a, b, h);
        #1;
        chk(tk_lo == t, {req, " taken"}, {31'd0, tk_lo}, {31'd0, t});
        chk(tk_hi == t, {req, " taken hi"}, {31'd0, tk_hi}, {31'd0, t});
        exp_lo = want_pc(exp_lo, k, t, h, off, tg);
        exp_hi = want_pc(exp_hi, k, t, h, off, tg);
        @(negedge clk);
        chk(pc_lo == exp_lo, {req, " pc"}, pc_lo, exp_lo);
        chk(pc_hi == exp_hi, {req, " pc hi"}, pc_hi, exp_hi);
        chk(pc_lo[1:0] == 2'b00 && pc_hi[1:0] == 2'b00, "R8 alignment",
            {pc_lo[1:0], pc_hi[1:0]}, 32'd0);
    endtask

    task automatic t_reset_r1;
        rst_n = 1'b0; kind_i = 3'd7;
        @(negedge clk); #1;
        chk(tk_lo == 1'b0, "R1 taken in reset", {31'd0, tk_lo}, 32'd0);
        @(negedge clk);
        chk(pc_lo == VEC_LO, "R1 reset vector", pc_lo, VEC_LO);
        chk(pc_hi == VEC_HI, "R1 reset vector hi", pc_hi, VEC_HI);
        rst_n = 1'b1; kind_i = 3'd0;
        exp_lo = VEC_LO; exp_hi = VEC_HI;
    endtask

    task automatic t_jump_r6;
        step("R6 jump all ones", 3'd7, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 1'b0);
        step("R6 jump pattern", 3'd7, 32'h0, 32'h0, 16'h0, 26'h123_4567, 1'b0);
        step("R6 jump all ones again", 3'd7, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 1'b0);
    endtask

    task automatic t_seq_r2;
        for (int i = 0; i < 3; i++)
            step("R2 sequential/wrap", 3'd0, 32'h5, 32'h5, 16'h7FFF, 26'h1, 1'b0);
    endtask

    task automatic t_equal_r3;
        step("R3 eq same", 3'd1, 32'hABCD_1234, 32'hABCD_1234, 16'd3, 26'h0, 1'b0);
        step("R3 eq differ", 3'd1, 32'hABCD_1234, 32'hABCD_1235, 16'd3, 26'h0, 1'b0);
        step("R3 ne differ", 3'd2, 32'h8000_0000, 32'h0, 16'd5, 26'h0, 1'b0);
        step("R3 ne same", 3'd2, 32'h7, 32'h7, 16'd5, 26'h0, 1'b0);
    endtask

    task automatic t_zero_r4;
        logic [31:0] vals [3] = '{32'hFFFF_FFFB, 32'h0, 32'h0000_0007};
        for (int k = 3; k <= 6; k++)
            for (int v = 0; v < 3; v++)
                step("R4 zero compare", 3'(k), vals[v], vals[2 - v] ^ 32'h1, 16'd2, 26'h0, 1'b0);
    endtask

    task automatic t_offset_r5;
        step("R5 forward", 3'd1, 32'h1, 32'h1, 16'd3, 26'h0, 1'b0);
        step("R5 backward", 3'd1, 32'h1, 32'h1, 16'hFFFE, 26'h0, 1'b0);
        step("R5 max forward", 3'd6, 32'h0, 32'h0, 16'h7FFF, 26'h0, 1'b0);
        step("R5 max backward", 3'd6, 32'h0, 32'h0, 16'h8000, 26'h0, 1'b0);
        step("R5 not taken", 3'd3, 32'h1, 32'h0, 16'h8000, 26'h0, 1'b0);
    endtask

    task automatic t_hold_r7;
        step("R7 hold jump", 3'd7, 32'h0, 32'h0, 16'h0, 26'h155_5555, 1'b1);
        step("R7 hold branch", 3'd1, 32'h2, 32'h2, 16'h10, 26'h0, 1'b1);
        step("R7 hold seq", 3'd0, 32'h0, 32'h0, 16'h0, 26'h0, 1'b1);
        step("R7 release", 3'd0, 32'h0, 32'h0, 16'h0, 26'h0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_r1();
        t_jump_r6();
        t_seq_r2();
        t_equal_r3();
        t_zero_r4();
        t_offset_r5();
        t_hold_r7();
        t_reset_r1();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule